// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt destination request into a bitmask with one bit per local interrupt controller. Each target is described by a table held at the ports: a present bit, an 8-bit physical ID, an 8-bit logical destination and a 4-bit addressing model (flat or cluster). A request is either given as separate fields (destination, physical/logical mode, shorthand, delivery mode, vector, trigger) or as a message-signalled address/data word pair, which the block decodes into the same fields.

The request is resolved in one pass. Physical IDs are looked up, or logical matching is done under each receiver's own model. The shorthand code is applied, absent targets are removed, and lowest-priority delivery keeps only one target. The result, along with the vector, delivery mode and trigger, is registered one cycle after the request strobe. Arbitration between targets and the injection of the interrupt are left to the logic that consumes the mask.

Top module: `irq_dest_resolver`

## Requirements
- R1: While reset is asserted and after reset, `out_valid` is 0 and `out_mask`, `out_vector`, `out_mode` and `out_trigger` are 0 until the first request.
- R2: A cycle with `req_valid` high causes `out_valid` to be high in the following cycle only, with the resolved fields loaded at that same edge.
- R3: In physical mode (`req_logical`=0) with shorthand 0, destination 0xFF selects every present target.
- R4: In physical mode with shorthand 0, any other destination selects every present target whose physical ID equals the destination.
- R5: In logical mode, a target with model 0xF (flat) is selected when the destination ANDed with its logical destination is non-zero.
- R6: In logical mode, a target with model 0x0 (cluster) is selected when bits 7:4 of the destination equal bits 7:4 of its logical destination and bits 3:0 of both share a set bit. A target with any other model is never selected in logical mode.
- R7: Shorthand 1 selects only the target numbered `req_self`. Shorthand 2 selects all targets. Shorthand 3 selects all except `req_self`. Shorthand 0 uses the addressed resolution of R3 to R6.
- R8: A target whose `tgt_present` bit is 0 is never set in the mask, even under broadcast or shorthand.
- R9: When the delivery mode is 1 (lowest priority), only the lowest-numbered selected target stays set. An empty selection stays empty.
- R10: With `req_msi`=1 the fields are taken from the message words. The destination comes from address bits 19:12, logical mode from address bit 2, the vector from data bits 7:0, the delivery mode from data bits 10:8 and the trigger from data bit 15. The shorthand input is ignored and treated as 0.
- R11: With `req_msi`=0 the vector, delivery mode and trigger inputs appear unchanged on the outputs together with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_msi | input | 1 | 1: decode the message words, 0: use the field inputs |
| req_dest | input | 8 | Destination |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_short | input | 2 | Shorthand: 0 addressed, 1 self, 2 all, 3 all but self |
| req_mode | input | 3 | Delivery mode (1 = lowest priority) |
| req_vector | input | 8 | Interrupt vector |
| req_trigger | input | 1 | Trigger mode |
| req_self | input | clog2(N_TGT) | Index of the sending target |
| msi_addr | input | 32 | Message address word |
| msi_data | input | 32 | Message data word |
| tgt_present | input | N_TGT | Per-target present bit |
| tgt_id | input | 8*N_TGT | Per-target physical IDs, target i at bits 8i+7:8i |
| tgt_ldest | input | 8*N_TGT | Per-target logical destinations, same packing |
| tgt_model | input | 4*N_TGT | Per-target model (0xF flat, 0x0 cluster), target i at bits 4i+3:4i |
| out_valid | output | 1 | Result valid pulse |
| out_mask | output | N_TGT | Delivery bitmask |
| out_vector | output | 8 | Resolved vector |
| out_mode | output | 3 | Resolved delivery mode |
| out_trigger | output | 1 | Resolved trigger mode |

## Verification
A fixed table is used. It mixes flat and cluster receivers, one receiver with an unknown model and one absent target. Physical broadcast and exact-ID requests separate the broadcast path from the ID compare, and a request aimed at the absent target's ID shows that presence masking comes last. Logical destinations are chosen to hit flat receivers only, and then flat and cluster receivers together, so that per-receiver model selection is exposed. All four shorthands, including self-only naming an absent sender, and lowest-priority requests over full, partial and empty selections show that ordering. Message words carrying a conflicting shorthand confirm the bit positions that are decoded.

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int N_TGT = 8,
  localparam int IW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_msi,
  input  logic [7:0]         req_dest,
  input  logic               req_logical,
  input  logic [1:0]         req_short,
  input  logic [2:0]         req_mode,
  input  logic [7:0]         req_vector,
  input  logic               req_trigger,
  input  logic [IW-1:0]      req_self,
  input  logic [31:0]        msi_addr,
  input  logic [31:0]        msi_data,
  input  logic [N_TGT-1:0]   tgt_present,
  input  logic [8*N_TGT-1:0] tgt_id,
  input  logic [8*N_TGT-1:0] tgt_ldest,
  input  logic [4*N_TGT-1:0] tgt_model,
  output logic               out_valid,
  output logic [N_TGT-1:0]   out_mask,
  output logic [7:0]         out_vector,
  output logic [2:0]         out_mode,
  output logic               out_trigger
);

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [2:0] MODE_LOWPRI   = 3'd1;

  wire [7:0] r_dest    = req_msi ? msi_addr[19:12] : req_dest;
  wire       r_logical = req_msi ? msi_addr[2]     : req_logical;
  wire [1:0] r_short   = req_msi ? 2'd0            : req_short;
  wire [7:0] r_vector  = req_msi ? msi_data[7:0]   : req_vector;
  wire [2:0] r_mode    = req_msi ? msi_data[10:8]  : req_mode;
  wire       r_trigger = req_msi ? msi_data[15]    : req_trigger;

  logic [N_TGT-1:0] addr_hit, self_bit, picked, sel, lowest, final_mask;

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    wire [7:0] lid = tgt_ldest[8*i +: 8];
    wire [3:0] mdl = tgt_model[4*i +: 4];
    wire phys_hit  = (r_dest == 8'hFF) || (r_dest == tgt_id[8*i +: 8]);
    wire flat_hit  = (mdl == MODEL_FLAT) && |(r_dest & lid);
    wire clus_hit  = (mdl == MODEL_CLUSTER) && (r_dest[7:4] == lid[7:4]) &&
                     |(r_dest[3:0] & lid[3:0]);
    assign addr_hit[i] = r_logical ? (flat_hit || clus_hit) : phys_hit;
    assign self_bit[i] = (req_self == IW'(i));
  end

  always_comb begin
    case (r_short)
      2'd0:    picked = addr_hit;
      2'd1:    picked = self_bit;
      2'd2:    picked = '1;
      default: picked = ~self_bit;
    endcase
  end

  assign sel        = picked & tgt_present;
  assign lowest     = sel & (~sel + N_TGT'(1));
  assign final_mask = (r_mode == MODE_LOWPRI) ? lowest : sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_mask    <= '0;
      out_vector  <= '0;
      out_mode    <= '0;
      out_trigger <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask    <= final_mask;
        out_vector  <= r_vector;
        out_mode    <= r_mode;
        out_trigger <= r_trigger;
      end
    end
  end

  assert_strobe_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  assert_broadcast_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_msi && req_short == 2'd2 && req_mode != MODE_LOWPRI)
      |=> (out_mask == $past(tgt_present)));
  assert_self_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_msi && req_short == 2'd1)
      |=> (out_mask == '0 || out_mask == (N_TGT'(1) << $past(req_self))));
  assert_absent_excluded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((out_mask & ~$past(tgt_present)) == '0));
  assert_lowpri_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && r_mode == MODE_LOWPRI) |=> $onehot0(out_mask));

endmodule

// File: tb/irq_dest_resolver_test.sv
`timescale 1ns/1ps
module irq_dest_resolver_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_msi = 0, req_logical = 0, req_trigger = 0;
  logic [7:0] req_dest = 0, req_vector = 0;
  logic [1:0] req_short = 0;
  logic [2:0] req_mode = 0;
  logic [IW-1:0] req_self = 0;
  logic [31:0] msi_addr = 0, msi_data = 0;
  logic [N-1:0] tgt_present;
  logic [8*N-1:0] tgt_id, tgt_ldest;
  logic [4*N-1:0] tgt_model;
  logic out_valid, out_trigger;
  logic [N-1:0] out_mask;
  logic [7:0] out_vector;
  logic [2:0] out_mode;

  int errors = 0, checks = 0;
  int pid[N], lds[N], mdl[N], pres[N];

  always #2.5 clk = ~clk;

  irq_dest_resolver #(.N_TGT(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msi(req_msi),
    .req_dest(req_dest), .req_logical(req_logical), .req_short(req_short),
    .req_mode(req_mode), .req_vector(req_vector), .req_trigger(req_trigger),
    .req_self(req_self), .msi_addr(msi_addr), .msi_data(msi_data),
    .tgt_present(tgt_present), .tgt_id(tgt_id), .tgt_ldest(tgt_ldest),
    .tgt_model(tgt_model), .out_valid(out_valid), .out_mask(out_mask),
    .out_vector(out_vector), .out_mode(out_mode), .out_trigger(out_trigger));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_mask(int d, int lg, int sh, int md, int self);
    int m = 0;
    for (int i = 0; i < N; i++) begin
      int hit = 0;
      case (sh)
        0: if (lg == 0) hit = (d == 255 || d == pid[i]);
           else if (mdl[i] == 15) hit = ((d & lds[i]) != 0);
           else if (mdl[i] == 0) hit = ((d / 16) == (lds[i] / 16)) && ((d & lds[i] & 15) != 0);
        1: hit = (i == self);
        2: hit = 1;
        default: hit = (i != self);
      endcase
      if (hit && pres[i]) m |= (1 << i);
    end
    if (md == 1)
      for (int i = 0; i < N; i++)
        if ((m >> i) & 1) return (1 << i);
    return m;
  endfunction

  task automatic send(string req, bit msi, int d, bit lg, int sh, int md,
                      int self, int vec, bit trg, int addr, int data);
    int ed, el, esh, ev, em, et, exp;
    @(negedge clk);
    req_msi = msi; req_dest = 8'(d); req_logical = lg; req_short = 2'(sh);
    req_mode = 3'(md); req_self = IW'(self); req_vector = 8'(vec);
    req_trigger = trg; msi_addr = addr; msi_data = data; req_valid = 1;
    if (msi) begin
      ed = (addr >> 12) & 255; el = (addr >> 2) & 1; esh = 0;
      ev = data & 255; em = (data >> 8) & 7; et = (data >> 15) & 1;
    end else begin
      ed = d; el = lg; esh = sh; ev = vec; em = md; et = trg;
    end
    exp = ref_mask(ed, el, esh, em, self);
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, out_valid, 1);
    check({req, " mask"}, out_mask, exp);
    check({req, " vector"}, out_vector, ev);
    check({req, " mode"}, out_mode, em);
    check({req, " trigger"}, out_trigger, et);
    @(negedge clk);
    check({req, " R2 idle valid"}, out_valid, 0);
    check({req, " R2 mask held"}, out_mask, exp);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pid[i] = 16 + i;
      pres[i] = (i != 6);
      if (i < 4) begin mdl[i] = 15; lds[i] = 1 << i; end
      else begin mdl[i] = (i == 5) ? 5 : 0; lds[i] = 32 + (1 << (i - 4)); end
      tgt_id[8*i +: 8] = 8'(pid[i]);
      tgt_ldest[8*i +: 8] = 8'(lds[i]);
      tgt_model[4*i +: 4] = 4'(mdl[i]);
      tgt_present[i] = pres[i][0];
    end
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 mask in reset", out_mask, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    check("R1 mask after reset", out_mask, 0);
    check("R1 vector after reset", out_vector, 0);

    send("R3 phys broadcast", 0, 8'hFF, 0, 0, 0, 0, 8'h20, 0, 0, 0);
    check("R3 R8 broadcast value", out_mask, 8'hBF);
    send("R4 phys id", 0, 8'h13, 0, 0, 0, 0, 8'h21, 1, 0, 0);
    check("R4 id value", out_mask, 8'h08);
    send("R8 R4 absent id", 0, 8'h16, 0, 0, 0, 0, 8'h22, 0, 0, 0);
    check("R8 absent id value", out_mask, 0);
    send("R5 flat", 0, 8'h05, 1, 0, 0, 0, 8'h23, 0, 0, 0);
    check("R5 flat value", out_mask, 8'h05);
    send("R6 cluster", 0, 8'h2F, 1, 0, 0, 0, 8'h24, 0, 0, 0);
    check("R6 cluster value", out_mask, 8'h9F);
    send("R6 mixed", 0, 8'h21, 1, 0, 2, 0, 8'h25, 1, 0, 0);
    check("R6 mixed value", out_mask, 8'h11);
    send("R6 bad model", 0, 8'h22, 1, 0, 0, 0, 8'h26, 0, 0, 0);
    check("R6 bad model value", out_mask, 8'h02);
    send("R7 self", 0, 8'h13, 0, 1, 0, 2, 8'h27, 0, 0, 0);
    check("R7 self value", out_mask, 8'h04);
    send("R7 R8 absent self", 0, 0, 0, 1, 0, 6, 8'h28, 0, 0, 0);
    check("R7 absent self value", out_mask, 0);
    send("R7 all", 0, 8'h13, 0, 2, 0, 3, 8'h29, 0, 0, 0);
    check("R7 all value", out_mask, 8'hBF);
    send("R7 others", 0, 8'h13, 0, 3, 0, 0, 8'h2A, 0, 0, 0);
    check("R7 others value", out_mask, 8'hBE);
    send("R9 lowpri broadcast", 0, 8'hFF, 0, 0, 1, 0, 8'h2B, 0, 0, 0);
    check("R9 lowpri broadcast value", out_mask, 8'h01);
    send("R9 lowpri logical", 0, 8'h2C, 1, 0, 1, 0, 8'h2C, 0, 0, 0);
    check("R9 lowpri logical value", out_mask, 8'h04);
    send("R9 lowpri empty", 0, 8'h40, 0, 0, 1, 0, 8'h2D, 0, 0, 0);
    check("R9 lowpri empty value", out_mask, 0);
    send("R10 msi phys", 1, 8'hFF, 1, 2, 0, 0, 8'h99, 0, 32'hFEE13000, 32'h00008041);
    check("R10 msi phys value", out_mask, 8'h08);
    check("R10 msi trigger", out_trigger, 1);
    send("R10 msi logical", 1, 0, 0, 3, 0, 0, 0, 0, 32'hFEE21004, 32'h00000230);
    check("R10 msi logical value", out_mask, 8'h11);
    check("R10 msi mode", out_mode, 2);
    send("R10 msi lowpri", 1, 0, 0, 1, 0, 5, 0, 1, 32'hFEE21004, 32'h00000130);
    check("R10 msi lowpri value", out_mask, 8'h01);
    send("R11 fields", 0, 8'h10, 0, 0, 5, 0, 8'hE7, 1, 0, 0);
    check("R11 vector value", out_vector, 8'hE7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule